// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block produces the strobes of a multiplexed external memory bus for an 8-bit microcontroller core. It counts oscillator clocks modulo 12, one machine cycle per lap. From that count it drives the address-latch pulse, the program-store strobe, and the data read and write strobes. It also muxes the low address byte and the write data onto one shared byte-wide bus, and chooses the source of the high address byte.

The core requests an external data move by holding the request inputs through phase 11 of a machine cycle. The request is sampled on the clock edge that starts the next cycle, and that whole cycle becomes a data cycle. The fetch-from-external flag, the latch-pulse disable bit and the table-read flag are captured on the same edge. A read cycle returns the byte found on the bus at the end of the read strobe, together with a one-clock valid flag.

Top module: `extBusSeq`

## Requirements
- R1: After reset, the outputs are idle: aleOut=0, psenN=1, rdN=1, wrN=1, busOe=0 and rdValid=0. In a cycle that is not a data cycle and has the latch pulse enabled, aleOut is high in phases 0-1 and again in phases 6-7, so each pulse lasts two clocks. Phase 0 is the first clock after the machine-cycle boundary edge.
- R2: In a data cycle, aleOut is high only in phases 0-1. The pulse in phases 6-7 is omitted.
- R3: When extFetch is set and the cycle is not a data cycle, psenN is low in phases 3-5 and 9-11. In every other cycle psenN stays high.
- R4: The latch pulse is enabled when any one of these holds: aleOff=0, extFetch=1, the cycle is a data cycle, or tableRead=1. Otherwise aleOut stays low for the whole cycle. This means aleOff has no effect while extFetch is set.
- R5: In a read data cycle (reqWrite=0), rdN is low in phases 5-10 and the bus is not driven from phase 2 on. The bus value at the end of phase 10 appears on rdData, with rdValid high in phase 11 only.
- R6: In a write data cycle (reqWrite=1), wrN is low in phases 5-10. From phase 2 through phase 11, busOe=1 and busOut carries reqWrData.
- R7: busOe=1 and busOut holds the low address byte in phase 0-1 of a data cycle (reqAddr[7:0]), and in phases 0-1 and 6-7 of an external fetch cycle that is not a data cycle (fetchAddr[7:0]). The bus is not driven in any phase that R6 or R7 does not name.
- R8: addrHi is reqAddr[15:8] in a data cycle with reqWide=1. It is portLatch in a data cycle with reqWide=0. Otherwise it is fetchAddr[15:8] when extFetch is set, and portLatch when it is not.
- R9: Request and mode inputs take effect only at the machine-cycle boundary. A request raised in the middle of a cycle leaves that cycle unchanged. At most one of aleOut, psenN low, rdN low and wrN low is active in any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | External data move requested for the next cycle |
| reqWrite | input | 1 | 1 = write move, 0 = read move |
| reqWide | input | 1 | 1 = 16-bit data address, 0 = 8-bit |
| reqAddr | input | ADDR_W | Data move address |
| reqWrData | input | DATA_W | Data to write |
| extFetch | input | 1 | Code is fetched from external memory |
| tableRead | input | 1 | Current instruction reads a code table |
| aleOff | input | 1 | Latch-pulse disable control bit |
| fetchAddr | input | ADDR_W | Code fetch address |
| portLatch | input | ADDR_W-DATA_W | Contents of the high-byte port register |
| busIn | input | DATA_W | Byte read from the shared bus |
| aleOut | output | 1 | Address-latch pulse, active high |
| psenN | output | 1 | Program-store strobe, active low |
| rdN | output | 1 | Data read strobe, active low |
| wrN | output | 1 | Data write strobe, active low |
| busOut | output | DATA_W | Byte driven onto the shared bus |
| busOe | output | 1 | Drive enable for busOut |
| addrHi | output | ADDR_W-DATA_W | High address byte |
| rdData | output | DATA_W | Captured read byte |
| rdValid | output | 1 | rdData updated, one clock |

## Verification
The assertions check every cycle that no two strobes overlap and that each latch pulse lasts two clocks. They also check that the program-store and data strobes open at fixed distances after a latch pulse falls, that data strobes last six clocks with no second latch pulse in their cycle, that write data holds steady while the write strobe is low, and that the bus is never driven during a read. Only the bench's sweep can show which cycles carry which pulses. That sweep covers every combination of fetch source, disable bit, table-read flag and data-move kind, and it compares the address and data values on both address bytes against the request. The late-request scenario shows that the boundary sampling of R9 holds.

// File: rtl/extBusPkg.sv
package extBusPkg;
  localparam int CYC_LEN = 12;
  localparam int PH_W = $clog2(CYC_LEN);
  localparam int ALE_LEN = 2;
  localparam int HALF = CYC_LEN / 2;
  localparam int STRB_LEN = 6;

  localparam logic [PH_W-1:0] PH_LAST     = PH_W'(CYC_LEN - 1);
  localparam logic [PH_W-1:0] PH_ALE_END  = PH_W'(ALE_LEN);
  localparam logic [PH_W-1:0] PH_HALF     = PH_W'(HALF);
  localparam logic [PH_W-1:0] PH_ALE2_END = PH_W'(HALF + ALE_LEN);
  localparam logic [PH_W-1:0] PH_PSEN_A   = PH_W'(ALE_LEN + 1);
  localparam logic [PH_W-1:0] PH_PSEN_B   = PH_W'(HALF + ALE_LEN + 1);
  localparam logic [PH_W-1:0] PH_STRB_A   = PH_W'(ALE_LEN + 3);
  localparam logic [PH_W-1:0] PH_STRB_Z   = PH_W'(ALE_LEN + 3 + STRB_LEN - 1);

  typedef struct packed {
    logic ale;
    logic psenN;
    logic rdN;
    logic wrN;
    logic driveAddr;
    logic driveData;
    logic startCyc;
    logic sampleRd;
  } strobeT;
endpackage

// File: rtl/ebsCtl.sv
module ebsCtl
  import extBusPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   reqWrite,
  input  logic   extFetch,
  input  logic   aleOff,
  input  logic   tableRead,
  output strobeT strb
);
  logic [PH_W-1:0] phaseQ, phN;
  logic dataQ, wrQ, fetchQ, aoQ, tblQ;
  logic dN, wN, fN, aoN, tN, boundary;
  logic inFirst, inSecond, aleEn, strbWin;
  logic aleD, psenND, rdND, wrND, drvAD, drvDD;
  logic aleQ, psenNQ, rdNQ, wrNQ, drvAQ, drvDQ;

  always_comb begin
    boundary = (phaseQ == PH_LAST);
    phN      = boundary ? '0 : phaseQ + PH_W'(1);
    dN  = boundary ? reqValid  : dataQ;
    wN  = boundary ? reqWrite  : wrQ;
    fN  = boundary ? extFetch  : fetchQ;
    aoN = boundary ? aleOff    : aoQ;
    tN  = boundary ? tableRead : tblQ;
    inFirst  = (phN < PH_ALE_END);
    inSecond = (phN >= PH_HALF) && (phN < PH_ALE2_END);
    aleEn    = dN || fN || !aoN || tN;
    strbWin  = (phN >= PH_STRB_A) && (phN <= PH_STRB_Z);
    aleD   = aleEn && (inFirst || (!dN && inSecond));
    psenND = !(fN && !dN && (((phN >= PH_PSEN_A) && (phN < PH_HALF)) || (phN >= PH_PSEN_B)));
    rdND   = !(dN && !wN && strbWin);
    wrND   = !(dN && wN && strbWin);
    drvAD  = (dN && inFirst) || (fN && !dN && (inFirst || inSecond));
    drvDD  = dN && wN && (phN >= PH_ALE_END);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= PH_LAST;
      dataQ <= 1'b0; wrQ <= 1'b0; fetchQ <= 1'b0; aoQ <= 1'b0; tblQ <= 1'b0;
      aleQ <= 1'b0; psenNQ <= 1'b1; rdNQ <= 1'b1; wrNQ <= 1'b1;
      drvAQ <= 1'b0; drvDQ <= 1'b0;
    end else begin
      phaseQ <= phN;
      dataQ <= dN; wrQ <= wN; fetchQ <= fN; aoQ <= aoN; tblQ <= tN;
      aleQ <= aleD; psenNQ <= psenND; rdNQ <= rdND; wrNQ <= wrND;
      drvAQ <= drvAD; drvDQ <= drvDD;
    end
  end

  always_comb begin
    strb.ale       = aleQ;
    strb.psenN     = psenNQ;
    strb.rdN       = rdNQ;
    strb.wrN       = wrNQ;
    strb.driveAddr = drvAQ;
    strb.driveData = drvDQ;
    strb.startCyc  = boundary;
    strb.sampleRd  = dataQ && !wrQ && (phaseQ == PH_STRB_Z);
  end

  // R9: strobes never overlap
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $countones({aleQ, !psenNQ, !rdNQ, !wrNQ}) <= 1);
  // R1: each latch pulse spans two clocks
  a_r1_ale_two_clocks: assert property (@(posedge clk) disable iff (!rstN)
    $fell(aleQ) |-> $past(aleQ, 2));
  // R3: program strobe opens one clock after the latch pulse ends
  a_r3_psen_after_ale: assert property (@(posedge clk) disable iff (!rstN)
    $fell(psenNQ) |-> ($past(aleQ, 2) && !$past(aleQ)));
  // R5: data strobes open three clocks after the latch pulse ends
  a_r5_strobe_delay: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rdNQ) || $fell(wrNQ)) |-> ($past(aleQ, 4) && !$past(aleQ, 3)));
  // R6: data strobes last six clocks
  a_r6_strobe_width: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rdNQ) || $rose(wrNQ)) |-> ($past(rdNQ && wrNQ, 7) && !$past(rdNQ && wrNQ, 6)));
  // R2: no second latch pulse inside a data cycle
  a_r2_no_second_ale: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rdNQ) || $rose(wrNQ)) |-> !$past(aleQ, 4));
endmodule

// File: rtl/ebsDp.sv
module ebsDp
  import extBusPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobeT                   strb,
  input  logic                     reqValid,
  input  logic                     reqWide,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWrData,
  input  logic                     extFetch,
  input  logic [ADDR_W-1:0]        fetchAddr,
  input  logic [ADDR_W-DATA_W-1:0] portLatch,
  input  logic [DATA_W-1:0]        busIn,
  output logic [DATA_W-1:0]        busOut,
  output logic                     busOe,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic [DATA_W-1:0]        rdData,
  output logic                     rdValid
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic              dpData, dpWide, dpFetch;
  logic [ADDR_W-1:0] dAddr, fAddr;
  logic [DATA_W-1:0] wData, lowAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dpData <= 1'b0; dpWide <= 1'b0; dpFetch <= 1'b0;
      dAddr <= '0; fAddr <= '0; wData <= '0;
    end else if (strb.startCyc) begin
      dpData  <= reqValid;
      dpWide  <= reqWide;
      dpFetch <= extFetch;
      dAddr   <= reqAddr;
      fAddr   <= fetchAddr;
      wData   <= reqWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.sampleRd;
      if (strb.sampleRd) rdData <= busIn;
    end
  end

  always_comb begin
    lowAddr = dpData ? dAddr[DATA_W-1:0] : fAddr[DATA_W-1:0];
    busOe   = strb.driveAddr || strb.driveData;
    if (strb.driveAddr)      busOut = lowAddr;
    else if (strb.driveData) busOut = wData;
    else                     busOut = '0;
    if (dpData)       addrHi = dpWide ? dAddr[ADDR_W-1:DATA_W] : portLatch;
    else if (dpFetch) addrHi = fAddr[ADDR_W-1:DATA_W];
    else              addrHi = portLatch;
  end

  logic [HI_W-1:0] unusedHi;
  assign unusedHi = '0;

  // R5: bus released while the read strobe is low
  a_r5_bus_free_on_read: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdN |-> !busOe);
  // R6: write data driven and steady through the write strobe
  a_r6_wdata_held: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrN && $past(!strb.wrN)) |-> (busOe && $stable(busOut)));
  // R5: read valid is a single-clock pulse
  a_r5_rdvalid_single: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);
endmodule

// File: rtl/extBusSeq.sv
module extBusSeq
  import extBusPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic                     reqWrite,
  input  logic                     reqWide,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWrData,
  input  logic                     extFetch,
  input  logic                     tableRead,
  input  logic                     aleOff,
  input  logic [ADDR_W-1:0]        fetchAddr,
  input  logic [ADDR_W-DATA_W-1:0] portLatch,
  input  logic [DATA_W-1:0]        busIn,
  output logic                     aleOut,
  output logic                     psenN,
  output logic                     rdN,
  output logic                     wrN,
  output logic [DATA_W-1:0]        busOut,
  output logic                     busOe,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic [DATA_W-1:0]        rdData,
  output logic                     rdValid
);
  strobeT strb;

  ebsCtl u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .extFetch(extFetch), .aleOff(aleOff), .tableRead(tableRead), .strb(strb)
  );

  ebsDp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqValid(reqValid), .reqWide(reqWide),
    .reqAddr(reqAddr), .reqWrData(reqWrData), .extFetch(extFetch),
    .fetchAddr(fetchAddr), .portLatch(portLatch), .busIn(busIn),
    .busOut(busOut), .busOe(busOe), .addrHi(addrHi), .rdData(rdData),
    .rdValid(rdValid)
  );

  assign aleOut = strb.ale;
  assign psenN  = strb.psenN;
  assign rdN    = strb.rdN;
  assign wrN    = strb.wrN;
endmodule

// File: tb/extBusSeq_bench.sv
module extBusSeq_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 0, reqWrite = 0, reqWide = 0, extFetch = 0, tableRead = 0, aleOff = 0;
  logic [15:0] reqAddr = 0, fetchAddr = 0;
  logic [7:0]  reqWrData = 0, portLatch = 0, busIn = 0;
  logic aleOut, psenN, rdN, wrN, busOe, rdValid;
  logic [7:0] busOut, addrHi, rdData;

  int total = 0;
  int bad = 0;

  logic cData, cWr, cWide, cFetch, cAo, cTbl;
  logic [15:0] cAddr, cFaddr;
  logic [7:0]  cWdat, cPort;

  always #5 clk = ~clk;

  extBusSeq u_extBusSeq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqWide(reqWide), .reqAddr(reqAddr), .reqWrData(reqWrData),
    .extFetch(extFetch), .tableRead(tableRead), .aleOff(aleOff),
    .fetchAddr(fetchAddr), .portLatch(portLatch), .busIn(busIn),
    .aleOut(aleOut), .psenN(psenN), .rdN(rdN), .wrN(wrN), .busOut(busOut),
    .busOe(busOe), .addrHi(addrHi), .rdData(rdData), .rdValid(rdValid)
  );

  task automatic chk(input string req, input int p, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s phase=%0d actual=%h expected=%h", req, p, act, exp);
    end
  endtask

  task automatic applyCfg();
    reqValid = cData; reqWrite = cWr; reqWide = cWide; reqAddr = cAddr;
    reqWrData = cWdat; extFetch = cFetch; aleOff = cAo; tableRead = cTbl;
    fetchAddr = cFaddr; portLatch = cPort; busIn = cAddr[7:0] ^ 8'h5A;
  endtask

  // runs one machine cycle; starts and ends in phase 11 just after a falling edge
  task automatic runCycle(input bit lateReq);
    logic aleEn, eAle, ePsenN, eRdN, eWrN, eOe, eAddrPh, eRv;
    logic [7:0] eBus, eHi;
    applyCfg();
    for (int p = 0; p < 12; p++) begin
      @(posedge clk);
      @(negedge clk);
      aleEn   = cData || cFetch || !cAo || cTbl;
      eAle    = aleEn && (p < 2 || (!cData && (p == 6 || p == 7)));
      ePsenN  = !(cFetch && !cData && ((p >= 3 && p <= 5) || p >= 9));
      eRdN    = !(cData && !cWr && p >= 5 && p <= 10);
      eWrN    = !(cData && cWr && p >= 5 && p <= 10);
      eAddrPh = (cData && p < 2) || (cFetch && !cData && (p < 2 || p == 6 || p == 7));
      eOe     = eAddrPh || (cData && cWr && p >= 2);
      eBus    = eAddrPh ? (cData ? cAddr[7:0] : cFaddr[7:0]) : cWdat;
      eHi     = cData ? (cWide ? cAddr[15:8] : cPort) : (cFetch ? cFaddr[15:8] : cPort);
      eRv     = cData && !cWr && p == 11;
      chk(cData ? "R2 ale" : (aleEn ? "R1 ale" : "R4 ale"), p, 16'(aleOut), 16'(eAle));
      chk("R3 psenN", p, 16'(psenN), 16'(ePsenN));
      chk("R5 rdN", p, 16'(rdN), 16'(eRdN));
      chk("R6 wrN", p, 16'(wrN), 16'(eWrN));
      chk("R7 busOe", p, 16'(busOe), 16'(eOe));
      if (eOe) chk(eAddrPh ? "R7 busOut" : "R6 busOut", p, 16'(busOut), 16'(eBus));
      chk("R8 addrHi", p, 16'(addrHi), 16'(eHi));
      chk("R5 rdValid", p, 16'(rdValid), 16'(eRv));
      if (eRv) chk("R5 rdData", p, 16'(rdData), 16'(cAddr[7:0] ^ 8'h5A));
      if (lateReq && p == 4) begin
        reqValid = 1'b1;  // R9: mid-cycle request must not change this cycle
        reqWrite = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int idx;
    repeat (3) @(negedge clk);
    // R1: idle outputs during reset
    chk("R1 reset ale", 0, 16'(aleOut), 16'd0);
    chk("R1 reset psenN", 0, 16'(psenN), 16'd1);
    chk("R1 reset rdN", 0, 16'(rdN), 16'd1);
    chk("R1 reset wrN", 0, 16'(wrN), 16'd1);
    chk("R1 reset busOe", 0, 16'(busOe), 16'd0);
    chk("R1 reset rdValid", 0, 16'(rdValid), 16'd0);
    rstN = 1'b1;
    idx = 0;
    for (int fe = 0; fe < 2; fe++)
      for (int ao = 0; ao < 2; ao++)
        for (int tb = 0; tb < 2; tb++)
          for (int k = 0; k < 5; k++) begin
            cFetch = fe[0]; cAo = ao[0]; cTbl = tb[0];
            cData = (k != 0); cWr = (k >= 3); cWide = (k == 2 || k == 4);
            cAddr  = 16'h1230 + 16'(idx * 16'h0107);
            cFaddr = 16'h4000 + 16'(idx * 16'h0213);
            cWdat  = 8'h3C + 8'(idx * 5);
            cPort  = 8'hC3 ^ 8'(idx);
            runCycle(1'b0);
            idx++;
          end
    // R9: request raised mid-cycle in an external fetch cycle
    cFetch = 1; cAo = 1; cTbl = 0; cData = 0; cWr = 0; cWide = 1;
    cAddr = 16'hBEEF; cFaddr = 16'h7A55; cWdat = 8'h99; cPort = 8'h0F;
    runCycle(1'b1);
    cData = 1;
    runCycle(1'b0);
    cData = 0; cFetch = 0;
    runCycle(1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule